// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Legacy Two-Register Model

This block puts an 8N1 asynchronous serial transmitter and receiver behind a two-location register window on an 8-bit peripheral bus. It keeps the register layout that older 8-bit system software expects. A write to the even location is a control write; a master-reset command sent there returns the serial engines to a known state. A read of the even location returns status flags. The odd location carries data: a write sends a byte and a read returns the last byte received.

Bus reads and writes use active-low strobes. Every register updates on the rising edge of one system clock. A baud enable input paces both serial engines. It pulses high for one clock, sixteen times per bit. The modem lines have no pins: carrier detect and clear to send always report their active (zero) level. An active-high interrupt output combines the receive and transmit conditions that software has enabled.

Top module: `acia_serial_port`

## Requirements
- R1: The block responds only when address bits 7..1 equal 0000010, that is at 0x04 and 0x05. A write elsewhere changes nothing. A read elsewhere, or any cycle with rdN high, returns 0x00 on busDataOut.
- R2: Status read at 0x04 has this layout: bit 0 receive-full, bit 1 transmit-empty, bits 2 and 3 (carrier, clear to send) always 0, bits 6..4 zero, and bit 7 equal to the irq output. After reset the status reads 0x02, irq is 0 and txd is 1.
- R3: A control write with bits 1:0 = 11 is a master reset. From the next cycle on, receive-full is 0, transmit-empty is 1, and txd is high and stays high with any frame in progress dropped.
- R4: A data write at 0x05 clears transmit-empty in the next cycle. When the transmitter is idle, it takes the byte one cycle later and transmit-empty returns to 1.
- R5: txd idles high. A frame is one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts 16 baud enables.
- R6: The receiver checks the start bit 8 enables after it first sees the line low. It then samples the data bits 16 enables apart, least significant first. It delivers the byte only if the stop bit samples high; otherwise receive-full stays 0.
- R7: A read at 0x05 returns the last received byte and clears receive-full. A status read does not clear it.
- R8: A byte that arrives while receive-full is still 1 replaces the held byte.
- R9: The control write sets bit 7 (receive interrupt enable) and bits 6:5 (transmit interrupt enabled only for the value 01). irq = (bit7 AND receive-full) OR (bits6:5 = 01 AND transmit-empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Peripheral address |
| busDataIn | input | 8 | Write data from the CPU |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| busDataOut | output | 8 | Read data, 0x00 when not addressed |
| baudTick | input | 1 | One-cycle enable, 16 per bit time |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request, active high |

## Verification
Read data is combinational while rdN is low, so the bench samples it one time unit after it drives the strobe, inside the same cycle. A register write shows in status at the next falling edge after the capturing rising edge. The transmitter loads a byte one edge after that, so transmit-empty is checked low in the cycle right after the write and high one cycle later. Serial results do not come at a fixed clock count. The bench counts baud enables instead: it samples txd eight enables after the start edge and every sixteen after that, and it polls status for receive-full with a timeout rather than waiting a fixed delay.

// File: rtl/acia_pkg.sv
package acia_pkg;
  localparam int BYTE_W = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic txLoad;       // move holding byte into the shifter
    logic engineReset;  // master reset of both serial engines
  } engCmd_t;

  // datapath -> control report
  typedef struct packed {
    logic              txBusy;
    logic              rxDone;
    logic [BYTE_W-1:0] rxByte;
  } engStat_t;
endpackage

// File: rtl/acia_ctrl.sv
module acia_ctrl
  import acia_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-2:0] BASE_SEL = 7'b0000010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busDataIn,
  input  logic              rdN,
  input  logic              wrN,
  output logic [BYTE_W-1:0] busDataOut,
  output logic              irq,
  input  engStat_t          stat,
  output engCmd_t           cmd,
  output logic [BYTE_W-1:0] txByte,
  output logic              txEmpty,
  output logic              rxFull
);
  logic selHit, regSel, wrEn, rdEn, mrCmd;
  logic rxIntEn;
  logic [1:0] txCtl;
  logic holdFull;
  logic [BYTE_W-1:0] rxData;

  assign selHit = (busAddr[ADDR_W-1:1] == BASE_SEL);
  assign regSel = busAddr[0];
  assign wrEn   = selHit && !wrN;
  assign rdEn   = selHit && !rdN;
  assign mrCmd  = wrEn && !regSel && (busDataIn[1:0] == 2'b11);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxIntEn  <= 1'b0;
      txCtl    <= 2'b00;
      txByte   <= '0;
      holdFull <= 1'b0;
      rxFull   <= 1'b0;
      rxData   <= '0;
    end else begin
      if (wrEn && !regSel) begin
        rxIntEn <= busDataIn[7];
        txCtl   <= busDataIn[6:5];
      end
      if (mrCmd) begin
        holdFull <= 1'b0;
        rxFull   <= 1'b0;
      end else begin
        if (wrEn && regSel) begin
          txByte   <= busDataIn;
          holdFull <= 1'b1;
        end else if (cmd.txLoad) begin
          holdFull <= 1'b0;
        end
        if (stat.rxDone) begin
          rxData <= stat.rxByte;
          rxFull <= 1'b1;
        end else if (rdEn && regSel) begin
          rxFull <= 1'b0;
        end
      end
    end
  end

  assign txEmpty = !holdFull;
  assign irq = (rxIntEn && rxFull) || ((txCtl == 2'b01) && txEmpty);

  always_comb begin
    cmd.txLoad      = holdFull && !stat.txBusy && !mrCmd;
    cmd.engineReset = mrCmd;
  end

  always_comb begin
    if (!rdEn)       busDataOut = '0;
    else if (regSel) busDataOut = rxData;
    else             busDataOut = {irq, 3'b000, 1'b0, 1'b0, txEmpty, rxFull};
  end
endmodule

// File: rtl/acia_datapath.sv
module acia_datapath
  import acia_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxd,
  input  engCmd_t           cmd,
  input  logic [BYTE_W-1:0] txByte,
  output engStat_t          stat,
  output logic              txd
);
  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} serState_t;

  // ---------------- transmitter ----------------
  serState_t txState;
  logic [CNT_W-1:0] txCnt;
  logic [BIT_W-1:0] txBit;
  logic [BYTE_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= S_IDLE;
      txCnt   <= '0;
      txBit   <= '0;
      txShift <= '0;
      txd     <= 1'b1;
    end else if (cmd.engineReset) begin
      txState <= S_IDLE;
      txCnt   <= '0;
      txd     <= 1'b1;
    end else if (cmd.txLoad) begin
      txShift <= txByte;
      txState <= S_START;
      txCnt   <= '0;
      txd     <= 1'b0;
    end else if (baudTick && txState != S_IDLE) begin
      if (txCnt == LAST) begin
        txCnt <= '0;
        case (txState)
          S_START: begin
            txState <= S_DATA;
            txBit   <= '0;
            txd     <= txShift[0];
            txShift <= txShift >> 1;
          end
          S_DATA: begin
            if (txBit == LAST_BIT) begin
              txState <= S_STOP;
              txd     <= 1'b1;
            end else begin
              txBit   <= txBit + 1'b1;
              txd     <= txShift[0];
              txShift <= txShift >> 1;
            end
          end
          default: txState <= S_IDLE;
        endcase
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // ---------------- receiver ----------------
  logic [1:0] rxSync;
  logic rxLine;
  serState_t rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [BIT_W-1:0] rxBit;
  logic [BYTE_W-1:0] rxShift;
  logic rxDone;

  assign rxLine = rxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxd};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= S_IDLE;
      rxCnt   <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      rxDone  <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (cmd.engineReset) begin
        rxState <= S_IDLE;
        rxCnt   <= '0;
      end else if (baudTick) begin
        case (rxState)
          S_IDLE: if (!rxLine) begin
            rxState <= S_START;
            rxCnt   <= '0;
          end
          S_START: begin
            if (rxCnt == HALF) begin
              rxCnt <= '0;
              rxBit <= '0;
              rxState <= rxLine ? S_IDLE : S_DATA;
            end else rxCnt <= rxCnt + 1'b1;
          end
          S_DATA: begin
            if (rxCnt == LAST) begin
              rxCnt   <= '0;
              rxShift <= {rxLine, rxShift[BYTE_W-1:1]};
              if (rxBit == LAST_BIT) rxState <= S_STOP;
              else                   rxBit   <= rxBit + 1'b1;
            end else rxCnt <= rxCnt + 1'b1;
          end
          default: begin
            if (rxCnt == LAST) begin
              rxCnt   <= '0;
              rxState <= S_IDLE;
              rxDone  <= rxLine;
            end else rxCnt <= rxCnt + 1'b1;
          end
        endcase
      end
    end
  end

  always_comb begin
    stat.txBusy = (txState != S_IDLE);
    stat.rxDone = rxDone;
    stat.rxByte = rxShift;
  end
endmodule

// File: rtl/acia_serial_port.sv
module acia_serial_port
  import acia_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-2:0] BASE_SEL   = 7'b0000010,
  parameter int                OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busDataIn,
  input  logic              rdN,
  input  logic              wrN,
  output logic [7:0]        busDataOut,
  input  logic              baudTick,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  engCmd_t           cmd;
  engStat_t          stat;
  logic [BYTE_W-1:0] txByte;
  logic              txEmpty;
  logic              rxFull;

  acia_ctrl #(.ADDR_W(ADDR_W), .BASE_SEL(BASE_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDataIn(busDataIn),
    .rdN(rdN), .wrN(wrN), .busDataOut(busDataOut), .irq(irq),
    .stat(stat), .cmd(cmd), .txByte(txByte), .txEmpty(txEmpty), .rxFull(rxFull)
  );

  acia_datapath #(.OVERSAMPLE(OVERSAMPLE)) u_dp (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxd(rxd),
    .cmd(cmd), .txByte(txByte), .stat(stat), .txd(txd)
  );
endmodule

// File: rtl/acia_serial_port_chk.sv
module acia_serial_port_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-2:0] BASE_SEL = 7'b0000010
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        ctlLow,
  input logic              rdN,
  input logic              wrN,
  input logic [7:0]        busDataOut,
  input logic              txd,
  input logic              irq,
  input logic              txEmpty,
  input logic              rxFull,
  input logic              txLoad,
  input logic              rxDone
);
  logic selHit, mrW, dataW, dataR, statR;
  assign selHit = (busAddr[ADDR_W-1:1] == BASE_SEL);
  assign mrW    = selHit && !wrN && !busAddr[0] && (ctlLow == 2'b11);
  assign dataW  = selHit && !wrN && busAddr[0];
  assign dataR  = selHit && !rdN && busAddr[0];
  assign statR  = selHit && !rdN && !busAddr[0];

  assert_no_response_R1: assert property (@(posedge clk) disable iff (!rstN)
    !selHit |-> busDataOut == 8'h00);
  assert_status_fields_R2: assert property (@(posedge clk) disable iff (!rstN)
    statR |-> (busDataOut[6:2] == 5'b0) && (busDataOut[0] == rxFull) && (busDataOut[1] == txEmpty));
  assert_master_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    mrW |=> txEmpty && !rxFull && txd);
  assert_write_clears_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataW |=> !txEmpty);
  assert_start_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txd);
  assert_read_clears_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataR && !rxDone) |=> !rxFull);
  assert_irq_in_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    statR |-> busDataOut[7] == irq);
endmodule

bind acia_serial_port acia_serial_port_chk #(.ADDR_W(ADDR_W), .BASE_SEL(BASE_SEL)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .ctlLow(busDataIn[1:0]),
  .rdN(rdN), .wrN(wrN), .busDataOut(busDataOut), .txd(txd), .irq(irq),
  .txEmpty(txEmpty), .rxFull(rxFull), .txLoad(cmd.txLoad), .rxDone(stat.rxDone)
);

// File: tb/acia_serial_port_bench.sv
module acia_serial_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busDataIn = 8'h00;
  logic rdN = 1'b1, wrN = 1'b1;
  logic [7:0] busDataOut;
  logic baudTick = 1'b0;
  logic txd, irq;
  logic loopMode = 1'b0, manualRx = 1'b1;
  logic [1:0] tickDiv = 2'd0;
  wire rxLine = loopMode ? txd : manualRx;
  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_DATA = 8'h05;

  // {data byte, control byte}
  localparam logic [15:0] VEC [0:5] = '{
    16'h5500, 16'hA380, 16'h0F20, 16'hF0A0, 16'h0140, 16'h8015 };

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tickDiv  <= tickDiv + 2'd1;
    baudTick <= (tickDiv == 2'd3);
  end

  acia_serial_port u_acia_serial_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDataIn(busDataIn),
    .rdN(rdN), .wrN(wrN), .busDataOut(busDataOut), .baudTick(baudTick),
    .rxd(rxLine), .txd(txd), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busDataIn = d; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; rdN = 1'b0;
    #1 d = busDataOut;
    @(negedge clk); rdN = 1'b1;
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!baudTick);
    end
  endtask

  task automatic sendSerial(input logic [7:0] b, input logic stopBit);
    logic [9:0] frame;
    frame = {stopBit, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); manualRx = frame[i];
      waitTicks(16);
    end
    @(negedge clk); manualRx = 1'b1;
  endtask

  task automatic captureTx(output logic [7:0] b, output logic stopBit);
    int guard;
    guard = 0;
    @(negedge clk);
    while (txd && guard < 5000) begin @(negedge clk); guard++; end
    waitTicks(8);
    for (int i = 0; i < 8; i++) begin
      waitTicks(16); @(negedge clk); b[i] = txd;
    end
    waitTicks(16); @(negedge clk); stopBit = txd;
  endtask

  task automatic pollRxFull(output logic [7:0] st);
    for (int i = 0; i < 400; i++) begin
      busRead(A_STAT, st);
      if (st[0]) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    logic [7:0] v;
    logic sb;
    logic [7:0] ctl;
    logic expIrq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // reset state (R2)
    busRead(A_STAT, v); check("R2 reset status", v, 8'h02);
    check("R2 reset txd", {7'b0, txd}, 8'h01);
    check("R2 reset irq", {7'b0, irq}, 8'h00);

    // decode (R1)
    busRead(8'h06, v); check("R1 read outside window", v, 8'h00);
    busWrite(8'h00, 8'h20);
    busRead(A_STAT, v); check("R1 write outside window ignored", v, 8'h02);
    @(negedge clk); check("R1 idle bus output", busDataOut, 8'h00);

    // transmit interrupt modes (R9)
    busWrite(A_STAT, 8'h20);
    busRead(A_STAT, v); check("R9 tx int 01", v, 8'h82);
    check("R9 irq pin", {7'b0, irq}, 8'h01);
    busWrite(A_STAT, 8'h40);
    busRead(A_STAT, v); check("R9 tx int 10", v, 8'h02);
    busWrite(A_STAT, 8'h60);
    busRead(A_STAT, v); check("R9 tx int 11", v, 8'h02);
    busWrite(A_STAT, 8'h00);

    // data write timing (R4) and frame (R5)
    @(negedge clk); busAddr = A_DATA; busDataIn = 8'hA5; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1; busAddr = A_STAT; rdN = 1'b0;
    #1 check("R4 empty cleared after write", busDataOut, 8'h00);
    @(negedge clk);
    #1 check("R4 empty restored after load", busDataOut, 8'h02);
    rdN = 1'b1;
    check("R5 start bit low", {7'b0, txd}, 8'h00);
    captureTx(v, sb);
    check("R5 tx byte", v, 8'hA5);
    check("R5 tx stop bit", {7'b0, sb}, 8'h01);
    waitTicks(20); @(negedge clk);
    check("R5 idle high", {7'b0, txd}, 8'h01);

    // table walk in loopback (R5, R6, R7, R9)
    loopMode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      ctl = VEC[k][7:0];
      busWrite(A_STAT, ctl);
      busWrite(A_DATA, VEC[k][15:8]);
      captureTx(v, sb);
      check("R5 table tx byte", v, VEC[k][15:8]);
      pollRxFull(v);
      expIrq = ctl[7] | (ctl[6:5] == 2'b01);
      check("R9 table status with byte", v, {expIrq, 7'b0000011});
      busRead(A_STAT, v);
      check("R7 status read keeps full", v[0] ? 8'h01 : 8'h00, 8'h01);
      busRead(A_DATA, v);
      check("R6 table rx byte", v, VEC[k][15:8]);
      busRead(A_STAT, v);
      expIrq = (ctl[6:5] == 2'b01);
      check("R7 data read clears full", v, {expIrq, 7'b0000010});
    end
    loopMode = 1'b0;
    busWrite(A_STAT, 8'h00);

    // overwrite (R8)
    sendSerial(8'h11, 1'b1);
    sendSerial(8'h22, 1'b1);
    busRead(A_STAT, v); check("R8 full after two bytes", v, 8'h03);
    busRead(A_DATA, v); check("R8 newest byte kept", v, 8'h22);

    // bad stop bit (R6)
    sendSerial(8'h33, 1'b0);
    waitTicks(16);
    busRead(A_STAT, v); check("R6 framing error dropped", v, 8'h02);

    // master reset (R3)
    sendSerial(8'h44, 1'b1);
    busWrite(A_DATA, 8'h00);
    waitTicks(40);
    busWrite(A_STAT, 8'h03);
    check("R3 txd high after reset", {7'b0, txd}, 8'h01);
    busRead(A_STAT, v); check("R3 status after reset", v, 8'h02);
    sb = 1'b1;
    for (int i = 0; i < 200; i++) begin @(negedge clk); sb = sb & txd; end
    check("R3 frame abandoned", {7'b0, sb}, 8'h01);

    finish();
  end
endmodule